// File: doc/BRIEF.md
# Multi-Hart Machine Timer Unit

This block keeps one free-running 64-bit time value for a group of harts, with a separate 64-bit compare register for each hart. The time value advances by one on every clock cycle in which the tick input is high. Tick generation and any clock-domain crossing of the tick happen outside the block. Software may rewrite the time value at any moment, and it may rewrite any compare register.

Each hart gets a level timer-interrupt output. That output is high while the time value is at or above the hart's compare value, using an unsigned comparison. Software clears it by moving the compare value above the time, or the time below the compare value. No acknowledge step exists.

The time value and the compare array are decoded in two separate address windows. Each window has its own select input, so another unit could sit behind a different time window. Both windows share a simple synchronous bus with 32-bit data and byte strobes. Every 64-bit register appears as two words. Hart indices are local to the block and run from 0 to `NUM_HARTS-1`, with at most 4095 harts.

Top module: `hart_timer_unit`

## Requirements
- R1: While reset is held low, the time value is forced to zero, every interrupt output is low and the read-data register is zero.
- R2: On each clock edge with tick high and no time-window write, the time value grows by exactly one. With tick low and no write, it holds.
- R3: In the time window, offset 0 holds bits 31:0 and offset 4 holds bits 63:32. A write merges only the bytes whose strobe bit is set and is visible on the next cycle. Any other offset, including any offset with address bits 1:0 nonzero, reads zero and ignores writes.
- R4: A time-window write and a tick in the same cycle produce exactly the written value. The tick is dropped.
- R5: The compare register of hart h is at offset 8·h (bits 31:0) and 8·h+4 (bits 63:32) of the compare window. It is written with byte strobes and reads back what was written.
- R6: Interrupt output h is high when the time value is greater than or equal to compare register h. It changes one cycle after the register change that causes it.
- R7: Interrupt output h is low whenever the time value is below compare register h. Raising the compare value or lowering the time value clears it with no other action.
- R8: A compare-window offset whose hart index is NUM_HARTS or above reads zero. A write there changes no compare register and no interrupt output.
- R9: A read returns, on the cycle after the request, the register value from before that clock edge. Between reads, the read data holds its last value.
- R10: The time value carries from bit 31 into bit 32. The compare treats both operands as unsigned 64-bit numbers.
- R11: A write in one window never changes a register in the other window at the same offset. The two selects are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Fixed-frequency advance strobe, one count per high cycle |
| sel_time | input | 1 | Selects the time-value window for this cycle's access |
| sel_cmp | input | 1 | Selects the compare-array window for this cycle's access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 15 | Byte offset inside the selected window |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte write strobes, bit b covers data bits 8b+7:8b |
| bus_rdata | output | 32 | Registered read data |
| timer_irq | output | NUM_HARTS | Level timer interrupt, one per hart |

## Verification
A register write lands at the edge that samples it, so a readback or a time-value effect is checked one cycle later. An interrupt output lags the register that drives it by one further edge. The bench therefore checks both the cycle directly after a compare or time write, where the old level must still show, and the cycle after that, where the new level is due. Read data is checked on the cycle after the request through a queue of expected words. A read issued while tick is high must return the count from before that edge. Tick stays low during every write unless the write-versus-tick priority is the subject of the check, so every expected time value can be counted exactly.

// File: rtl/htu_pkg.sv
// Shared widths, types and the byte-strobe merge helper for the
// multi-hart machine timer. Assumes 32-bit bus words and 64-bit registers.
package htu_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned TIME_W    = 64;
    localparam int unsigned STRB_W    = WORD_W / 8;
    localparam int unsigned MAX_HARTS = 4095;
    localparam int unsigned ADDR_W    = 15;           // 4095 x 8 bytes fits below 0x8000
    localparam int unsigned IDX_W     = ADDR_W - 3;   // hart index field, 8 bytes per hart

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [TIME_W-1:0] tval_t;
    typedef logic [STRB_W-1:0] strb_t;

    // Replace only the bytes of cur whose strobe bit is set.
    function automatic word_t strobe_merge(word_t cur, word_t nw, strb_t s);
        word_t r;
        r = cur;
        for (int b = 0; b < int'(STRB_W); b++) begin
            if (s[b]) r[8*b +: 8] = nw[8*b +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/htu_time_counter.sv
// Free-running 64-bit time value. It advances by one per cycle with tick high.
// A software word write (with byte strobes) wins over a tick in the same cycle.
// Assumes tick is already synchronous to clk.
module htu_time_counter
    import htu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  logic  wr_lo_i,
    input  logic  wr_hi_i,
    input  word_t wdata_i,
    input  strb_t strb_i,
    output tval_t count_o
);
    tval_t cnt_q;
    tval_t cnt_next;

    // Next value: a software write first, else a tick increment, else hold.
    always_comb begin
        cnt_next = cnt_q;
        if (wr_lo_i || wr_hi_i) begin
            if (wr_lo_i) cnt_next[WORD_W-1:0]      = strobe_merge(cnt_q[WORD_W-1:0], wdata_i, strb_i);
            if (wr_hi_i) cnt_next[TIME_W-1:WORD_W] = strobe_merge(cnt_q[TIME_W-1:WORD_W], wdata_i, strb_i);
        end else if (tick_i) begin
            cnt_next = cnt_q + tval_t'(1);
        end
    end

    // Counter register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_next;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/htu_cmp_bank.sv
// One 64-bit compare register per hart, written a word at a time with
// byte strobes. It also provides the read word for an indexed hart.
// Reset loads all ones, so no interrupt fires before software programs it.
// Assumes the caller blocks indices at or above NUM_HARTS.
module htu_cmp_bank
    import htu_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic                        hi_i,
    input  word_t                       wdata_i,
    input  strb_t                       strb_i,
    output word_t                       rd_word_o,
    output logic [NUM_HARTS*TIME_W-1:0] cmp_flat_o
);
    genvar h;
    generate
        for (h = 0; h < int'(NUM_HARTS); h++) begin : g_hart
            tval_t cmp_q;
            logic  hit;

            assign hit = wr_en_i && (idx_i == IDX_W'(h));

            // Per-hart compare register, updated when this hart's index is written.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cmp_q <= '1;
                end else if (hit) begin
                    if (hi_i) cmp_q[TIME_W-1:WORD_W] <= strobe_merge(cmp_q[TIME_W-1:WORD_W], wdata_i, strb_i);
                    else      cmp_q[WORD_W-1:0]      <= strobe_merge(cmp_q[WORD_W-1:0], wdata_i, strb_i);
                end
            end

            assign cmp_flat_o[h*TIME_W +: TIME_W] = cmp_q;
        end
    endgenerate

    // Read select: the addressed hart's upper or lower word, zero if no hart matches.
    always_comb begin
        rd_word_o = '0;
        for (int k = 0; k < int'(NUM_HARTS); k++) begin
            if (idx_i == IDX_W'(k)) begin
                rd_word_o = hi_i ? cmp_flat_o[k*TIME_W+WORD_W +: WORD_W]
                                 : cmp_flat_o[k*TIME_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/htu_irq_gen.sv
// Registered per-hart timer interrupts. Each output is the unsigned
// comparison time >= compare, taken one edge after its operands.
module htu_irq_gen
    import htu_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  tval_t                       time_i,
    input  logic [NUM_HARTS*TIME_W-1:0] cmp_flat_i,
    output logic [NUM_HARTS-1:0]        irq_o
);
    logic [NUM_HARTS-1:0] irq_q;

    // Level comparison for every hart, registered to cut the 64-bit compare path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            for (int h = 0; h < int'(NUM_HARTS); h++) begin
                irq_q[h] <= (time_i >= cmp_flat_i[h*TIME_W +: TIME_W]);
            end
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/hart_timer_unit.sv
// Top of the multi-hart machine timer. It decodes the time window and the
// compare window, registers read data, and drives one level interrupt per hart.
// Assumes sel_time and sel_cmp are never high together, and that offsets are
// word aligned (unaligned offsets read zero and ignore writes).
module hart_timer_unit
    import htu_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 sel_time,
    input  logic                 sel_cmp,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    input  logic [STRB_W-1:0]    bus_strb,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic [NUM_HARTS-1:0] timer_irq
);
    generate
        if (NUM_HARTS < 1 || NUM_HARTS > MAX_HARTS) begin : g_bad_count
            $error("hart_timer_unit: NUM_HARTS must lie in 1..4095");
        end
    endgenerate

    logic [IDX_W-1:0]            addr_idx;
    logic                        addr_hi;
    logic                        aligned;
    logic                        time_hit;
    logic                        cmp_hit;
    tval_t                       time_q;
    word_t                       cmp_word;
    word_t                       rd_next;
    word_t                       rdata_q;
    logic [NUM_HARTS*TIME_W-1:0] cmp_flat;

    // Address decode shared by both windows.
    assign addr_idx = bus_addr[ADDR_W-1:3];
    assign addr_hi  = bus_addr[2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign time_hit = sel_time && aligned && (addr_idx == '0);
    assign cmp_hit  = sel_cmp && aligned && (32'(addr_idx) < NUM_HARTS);

    htu_time_counter u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .wr_lo_i (time_hit && bus_we && !addr_hi),
        .wr_hi_i (time_hit && bus_we && addr_hi),
        .wdata_i (bus_wdata),
        .strb_i  (bus_strb),
        .count_o (time_q)
    );

    htu_cmp_bank #(.NUM_HARTS(NUM_HARTS)) u_cmp_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (cmp_hit && bus_we),
        .idx_i      (addr_idx),
        .hi_i       (addr_hi),
        .wdata_i    (bus_wdata),
        .strb_i     (bus_strb),
        .rd_word_o  (cmp_word),
        .cmp_flat_o (cmp_flat)
    );

    htu_irq_gen #(.NUM_HARTS(NUM_HARTS)) u_irq_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .time_i     (time_q),
        .cmp_flat_i (cmp_flat),
        .irq_o      (timer_irq)
    );

    // Read word selection. Anything outside a decoded register returns zero.
    always_comb begin
        if (time_hit)     rd_next = addr_hi ? time_q[TIME_W-1:WORD_W] : time_q[WORD_W-1:0];
        else if (cmp_hit) rd_next = cmp_word;
        else              rd_next = '0;
    end

    // Read-data register. It loads on a read in either window and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                                rdata_q <= '0;
        else if ((sel_time || sel_cmp) && !bus_we) rdata_q <= rd_next;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/htu_checker.sv
// Temporal checks for the multi-hart machine timer, bound into the top.
module htu_checker
    import htu_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        tick,
    input logic                        sel_time,
    input logic                        sel_cmp,
    input logic                        bus_we,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [WORD_W-1:0]           bus_wdata,
    input logic [STRB_W-1:0]           bus_strb,
    input logic [WORD_W-1:0]           bus_rdata,
    input logic [NUM_HARTS-1:0]        timer_irq,
    input tval_t                       time_q,
    input logic [NUM_HARTS*TIME_W-1:0] cmp_flat
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (time_q == '0 && timer_irq == '0 && bus_rdata == '0));

    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(sel_time && bus_we)) |=> time_q == $past(time_q) + tval_t'(1));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(sel_time && bus_we)) |=> $stable(time_q));

    // R4
    write_over_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_time && bus_we && bus_addr == '0 && bus_strb == '1) |=> time_q[WORD_W-1:0] == $past(bus_wdata));

    // R8
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_cmp && bus_we && 32'(bus_addr[ADDR_W-1:3]) >= NUM_HARTS) |=> $stable(cmp_flat));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((sel_time || sel_cmp) && !bus_we) |=> $stable(bus_rdata));

    // R11
    one_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_time && sel_cmp));

    genvar h;
    generate
        for (h = 0; h < int'(NUM_HARTS); h++) begin : g_irq
            // R6 R7
            irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
                timer_irq[h] == $past(time_q >= cmp_flat[h*TIME_W +: TIME_W]));
        end
    endgenerate
endmodule

bind hart_timer_unit htu_checker #(.NUM_HARTS(NUM_HARTS)) u_htu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .sel_time  (sel_time),
    .sel_cmp   (sel_cmp),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_strb  (bus_strb),
    .bus_rdata (bus_rdata),
    .timer_irq (timer_irq),
    .time_q    (time_q),
    .cmp_flat  (cmp_flat)
);

// File: tb/hart_timer_unit_bench.sv
// Scoreboard bench: read tasks queue expected words, a monitor pops and compares.
module hart_timer_unit_bench;
    localparam int NH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          sel_time = 1'b0;
    logic          sel_cmp = 1'b0;
    logic          bus_we = 1'b0;
    logic [14:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [3:0]    bus_strb = '0;
    logic [31:0]   bus_rdata;
    logic [NH-1:0] timer_irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_pend = 1'b0;

    always #5 clk = ~clk;

    hart_timer_unit #(.NUM_HARTS(NH)) u_hart_timer_unit (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sel_time(sel_time), .sel_cmp(sel_cmp),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_strb(bus_strb),
        .bus_rdata(bus_rdata), .timer_irq(timer_irq)
    );

    // A read sampled at this edge has its data due by the next falling edge.
    always @(posedge clk) rd_pend <= (sel_time || sel_cmp) && !bus_we;

    // Monitor: compare each due read against the front of the queue.
    always @(negedge clk) begin
        if (rd_pend) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R9 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input bit twin, input int unsigned off, input logic [31:0] d, input logic [3:0] s);
        sel_time = twin; sel_cmp = !twin; bus_we = 1'b1;
        bus_addr = 15'(off); bus_wdata = d; bus_strb = s;
        @(negedge clk);
        sel_time = 1'b0; sel_cmp = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input bit twin, input int unsigned off, input logic [31:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        sel_time = twin; sel_cmp = !twin; bus_we = 1'b0; bus_addr = 15'(off);
        @(negedge clk);
        sel_time = 1'b0; sel_cmp = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic [NH-1:0] e, input string t);
        checks++;
        if (timer_irq !== e) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", t, timer_irq, e);
        end
    endtask

    task automatic chk_rdata(input logic [31:0] e, input string t);
        checks++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s rdata actual=%h expected=%h", t, bus_rdata, e);
        end
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk_irq('0, "R1 irq after reset");
        chk_rdata('0, "R1 rdata after reset");
        rd(1, 0, 32'h0, "R1 time lo");
        rd(1, 4, 32'h0, "R1 time hi");

        // R5: program compare registers 0x100 * (h+1)
        for (int h = 0; h < NH; h++) begin
            wr(0, 8*h, 32'h100 * (h + 1), 4'hF);
            wr(0, 8*h + 4, 32'h0, 4'hF);
        end
        rd(0, 16, 32'h300, "R5 cmp2 lo");
        rd(0, 20, 32'h0, "R5 cmp2 hi");
        wr(0, 28, 32'h12345678, 4'b0100);
        rd(0, 28, 32'h00340000, "R5 cmp3 hi strobe");
        wr(0, 28, 32'h0, 4'hF);

        // R2: exactly 0x250 ticks
        tick = 1'b1; cyc(32'h250); tick = 1'b0;
        cyc(1);
        chk_irq(4'b0011, "R6 after ticking");
        rd(1, 0, 32'h250, "R2 count after ticks");

        // R7: raising cmp1 clears it, one edge after the register changes (R6 latency)
        wr(0, 8, 32'h1000, 4'hF);
        chk_irq(4'b0011, "R6 irq not yet updated");
        cyc(1);
        chk_irq(4'b0001, "R7 compare raised");
        wr(0, 16, 32'h250, 4'hF);
        cyc(1);
        chk_irq(4'b0101, "R6 equal fires");

        // R3 R7: lower the time value
        wr(1, 0, 32'h10, 4'hF);
        cyc(1);
        chk_irq(4'b0000, "R7 time lowered");
        rd(1, 0, 32'h10, "R3 time lo write");
        rd(1, 4, 32'h0, "R3 time hi");
        wr(1, 0, 32'hAABBCCDD, 4'b0010);
        rd(1, 0, 32'h0000CC10, "R3 strobed time write");
        chk_irq(4'b1111, "R6 after strobed write");

        // R10: unsigned compare with bit 63 set
        wr(1, 4, 32'h1, 4'hF);
        wr(0, 28, 32'h80000000, 4'hF);
        cyc(1);
        chk_irq(4'b0111, "R10 unsigned compare");

        // R3: unused and unaligned time offsets
        wr(1, 8, 32'hDEAD, 4'hF);
        wr(1, 1, 32'hBEEF, 4'hF);
        rd(1, 0, 32'h0000CC10, "R3 unused offset write ignored");
        rd(1, 4, 32'h1, "R3 hi after ignored writes");
        rd(1, 8, 32'h0, "R3 unused offset reads zero");

        // R10: carry into the upper word
        wr(1, 0, 32'hFFFFFFFE, 4'hF);
        wr(1, 4, 32'h5, 4'hF);
        tick = 1'b1; cyc(3); tick = 1'b0;
        rd(1, 4, 32'h6, "R10 carry hi");
        rd(1, 0, 32'h1, "R10 carry lo");

        // R4: write and tick in the same cycle
        tick = 1'b1;
        wr(1, 0, 32'h1234, 4'hF);
        tick = 1'b0;
        rd(1, 0, 32'h1234, "R4 write beats tick");
        rd(1, 4, 32'h6, "R4 hi unchanged");
        chk_irq(4'b0111, "R6 after priority write");

        // R8: beyond the last hart
        wr(0, 8*NH, 32'h0, 4'hF);
        wr(0, 8*NH + 4, 32'h0, 4'hF);
        cyc(1);
        chk_irq(4'b0111, "R8 stray write no irq change");
        rd(0, 8*NH, 32'h0, "R8 stray reads zero");
        rd(0, 32'h7FF8, 32'h0, "R8 top offset reads zero");
        rd(0, 0, 32'h100, "R8 cmp0 not aliased");
        rd(0, 28, 32'h80000000, "R8 cmp3 intact");

        // R11: window independence
        wr(0, 0, 32'h7, 4'hF);
        wr(0, 4, 32'h7, 4'hF);
        cyc(1);
        chk_irq(4'b0110, "R11 cmp0 rewritten");
        rd(1, 0, 32'h1234, "R11 time untouched by compare write");
        rd(0, 8, 32'h1000, "R11 cmp1 untouched by time write");

        // R9: pre-edge value and hold
        tick = 1'b1;
        rd(1, 0, 32'h1234, "R9 read returns pre-edge value");
        tick = 1'b0;
        rd(1, 0, 32'h1235, "R9 read after tick");
        cyc(3);
        chk_rdata(32'h1235, "R9 rdata holds");

        cyc(2);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R9 reads left unanswered actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1..all actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule